// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

The router takes a vector of level device interrupt requests and distributes them to a small group of processors. Each processor owns an enable mask. The block samples the raw request vector into a register on every clock. For each processor it keeps a routed vector, which is the AND of that processor's mask and the sampled requests. Each processor's interrupt line is high exactly when its routed vector has any bit set. Software writes a new mask to raise or drop a processor's line, and an interrupt stays consistent when device requests come and go.

Access goes through a single-cycle register port. A request lasts one cycle. The register index is the address shifted right by six, so every register sits on its own 64-byte slot. Mask register `c` is at index `c`. Routed register `c` is at index `NUM_CPU + c`. The sampled raw vector is at index `2*NUM_CPU`. A legal read returns its data one cycle after the request. An illegal access returns an error pulse in that same cycle and changes no state.

Top module: `irq_router`

## Requirements
- R1: After reset every mask, every routed vector and the raw vector read as zero, and `irq_o`, `rsp_valid_o` and `err_o` are low.
- R2: The raw register takes the value of `dev_irq_i` on every clock edge. It reads back at index `2*NUM_CPU`.
- R3: A 64-bit write to index `c` (`c < NUM_CPU`) replaces mask `c` at that clock edge. The mask reads back at index `c`, and the write leaves the other masks unchanged.
- R4: Routed register `c` reads at index `NUM_CPU + c` and always equals mask `c` AND raw. Both a mask write and a raw change update it at the same edge as the register they alter.
- R5: `irq_o[c]` is high exactly when routed register `c` is non-zero. Setting a mask bit whose request is pending raises the line. Clearing the last routed bit, through a mask write or a falling request, drops the line. Lines of other CPUs do not change.
- R6: A write to a routed register or to the raw register pulses `err_o` one cycle later and changes no register.
- R7: An access with `req_size_i` other than 3 is rejected: `err_o` pulses, `rsp_valid_o` stays low, and a write does not land. Size codes: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64.
- R8: An access to an index above `2*NUM_CPU` pulses `err_o` and returns no read data.
- R9: A legal read drives `rsp_valid_o` high for exactly one cycle, one cycle after the request, with the register value on `rsp_rdata_o`. `err_o` is never high in the same cycle as `rsp_valid_o`.
- R10: Address bits 5 to 0 do not affect which register is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dev_irq_i | input | DATA_W | Raw device interrupt request levels |
| req_valid_i | input | 1 | Register access request, one cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address; bits ADDR_W-1 to 6 give the index |
| req_size_i | input | 2 | Access size code |
| req_wdata_i | input | DATA_W | Write data |
| rsp_rdata_o | output | DATA_W | Read data, valid with rsp_valid_o |
| rsp_valid_o | output | 1 | Read response pulse |
| err_o | output | 1 | Illegal-access pulse |
| irq_o | output | NUM_CPU | Level interrupt per processor |

## Verification
The hardest situation to reach is a mask write that changes one CPU's line while the other three lines must hold still, together with its mirror case: a line that drops only because a request fell, with no register write at all. The bench sweeps a set of raw patterns. Under each pattern it rewrites every CPU's mask, with alternate masks overlapping the requests or avoiding them. After every single write it compares the whole `irq_o` vector against a bench-side mirror of masks AND raw. Separate phases clear one mask out of an all-enabled set and pull the raw requests to zero underneath fixed masks.

// File: rtl/irq_rtr_pkg.sv
package irq_rtr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RK_MASK   = 2'd0,
        RK_ROUTED = 2'd1,
        RK_RAW    = 2'd2,
        RK_NONE   = 2'd3
    } reg_kind_e;

    localparam int unsigned SLOT_SHIFT = 6;

endpackage

// File: rtl/irq_rtr_decode.sv
module irq_rtr_decode
    import irq_rtr_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned ADDR_W  = 10,
    localparam int unsigned IDX_W  = ADDR_W - SLOT_SHIFT,
    localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               valid_i,
    input  logic               write_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [1:0]         size_i,
    output reg_kind_e          kind_o,
    output logic [CPU_W-1:0]   cpu_o,
    output logic [NUM_CPU-1:0] wr_sel_o,
    output logic               rd_ok_o,
    output logic               bad_o
);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] rel;
    logic             size_ok;
    logic             wr_ok;

    assign idx     = addr_i[ADDR_W-1:SLOT_SHIFT];
    assign size_ok = (size_i == SZ_DWORD);

    always_comb begin
        kind_o = RK_NONE;
        rel    = '0;
        if (idx < IDX_W'(NUM_CPU)) begin
            kind_o = RK_MASK;
            rel    = idx;
        end else if (idx < IDX_W'(2 * NUM_CPU)) begin
            kind_o = RK_ROUTED;
            rel    = idx - IDX_W'(NUM_CPU);
        end else if (idx == IDX_W'(2 * NUM_CPU)) begin
            kind_o = RK_RAW;
        end
    end

    assign cpu_o   = rel[CPU_W-1:0];
    assign wr_ok   = valid_i && write_i && size_ok && (kind_o == RK_MASK);
    assign rd_ok_o = valid_i && !write_i && size_ok && (kind_o != RK_NONE);
    assign bad_o   = valid_i && (!size_ok || (kind_o == RK_NONE) ||
                                 (write_i && (kind_o != RK_MASK)));

    always_comb begin
        wr_sel_o = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            wr_sel_o[c] = wr_ok && (cpu_o == CPU_W'(c));
        end
    end

endmodule

// File: rtl/irq_rtr_cpu_slice.sv
module irq_rtr_cpu_slice #(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] mask_q_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [DATA_W-1:0] raw_d_i,
    input  logic [DATA_W-1:0] routed_q_i,
    output logic [DATA_W-1:0] mask_d_o,
    output logic [DATA_W-1:0] routed_d_o,
    output logic              irq_o
);

    assign mask_d_o   = wr_en_i ? wr_data_i : mask_q_i;
    assign routed_d_o = mask_d_o & raw_d_i;
    assign irq_o      = |routed_q_i;

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_rtr_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned ADDR_W  = 10,
    localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [DATA_W-1:0]  dev_irq_i,
    input  logic               req_valid_i,
    input  logic               req_write_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    input  logic [1:0]         req_size_i,
    input  logic [DATA_W-1:0]  req_wdata_i,
    output logic [DATA_W-1:0]  rsp_rdata_o,
    output logic               rsp_valid_o,
    output logic               err_o,
    output logic [NUM_CPU-1:0] irq_o
);

    typedef struct packed {
        logic [NUM_CPU-1:0][DATA_W-1:0] mask;
        logic [NUM_CPU-1:0][DATA_W-1:0] routed;
        logic [DATA_W-1:0]              raw;
        logic [DATA_W-1:0]              rdata;
        logic                           rd_valid;
        logic                           err;
    } state_t;

    state_t state_d, state_q;

    reg_kind_e                      dec_kind;
    logic [CPU_W-1:0]               dec_cpu;
    logic [NUM_CPU-1:0]             dec_wr_sel;
    logic                           dec_rd_ok;
    logic                           dec_bad;
    logic [NUM_CPU-1:0][DATA_W-1:0] mask_nx;
    logic [NUM_CPU-1:0][DATA_W-1:0] routed_nx;

    irq_rtr_decode #(
        .NUM_CPU (NUM_CPU),
        .ADDR_W  (ADDR_W)
    ) u_decode (
        .valid_i  (req_valid_i),
        .write_i  (req_write_i),
        .addr_i   (req_addr_i),
        .size_i   (req_size_i),
        .kind_o   (dec_kind),
        .cpu_o    (dec_cpu),
        .wr_sel_o (dec_wr_sel),
        .rd_ok_o  (dec_rd_ok),
        .bad_o    (dec_bad)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        irq_rtr_cpu_slice #(
            .DATA_W (DATA_W)
        ) u_slice (
            .mask_q_i   (state_q.mask[c]),
            .wr_en_i    (dec_wr_sel[c]),
            .wr_data_i  (req_wdata_i),
            .raw_d_i    (dev_irq_i),
            .routed_q_i (state_q.routed[c]),
            .mask_d_o   (mask_nx[c]),
            .routed_d_o (routed_nx[c]),
            .irq_o      (irq_o[c])
        );
    end

    always_comb begin
        logic [DATA_W-1:0] rd_val;
        state_d        = state_q;
        state_d.raw    = dev_irq_i;
        state_d.mask   = mask_nx;
        state_d.routed = routed_nx;

        unique case (dec_kind)
            RK_MASK:   rd_val = state_q.mask[dec_cpu];
            RK_ROUTED: rd_val = state_q.routed[dec_cpu];
            RK_RAW:    rd_val = state_q.raw;
            default:   rd_val = '0;
        endcase

        state_d.rd_valid = dec_rd_ok;
        state_d.rdata    = dec_rd_ok ? rd_val : '0;
        state_d.err      = dec_bad;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_rdata_o = state_q.rdata;
    assign rsp_valid_o = state_q.rd_valid;
    assign err_o       = state_q.err;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned ADDR_W  = 10
) (
    input logic                           clk_i,
    input logic                           rst_ni,
    input logic [DATA_W-1:0]              dev_irq_i,
    input logic                           req_valid_i,
    input logic                           req_write_i,
    input logic [ADDR_W-1:0]              req_addr_i,
    input logic [1:0]                     req_size_i,
    input logic                           rsp_valid_o,
    input logic                           err_o,
    input logic [NUM_CPU-1:0]             irq_o,
    input logic [NUM_CPU-1:0][DATA_W-1:0] mask_i,
    input logic [DATA_W-1:0]              raw_i
);

    logic [ADDR_W-7:0] idx;
    assign idx = req_addr_i[ADDR_W-1:6];

    AST_RAW_TRACKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (raw_i == $past(dev_irq_i))) else $error("raw sample"); // R2

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
        AST_IRQ_IS_ROUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[c] == (|(mask_i[c] & raw_i))) else $error("irq routing"); // R5
    end

    AST_BAD_SIZE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && (req_size_i != 2'd3)) |=> (err_o && !rsp_valid_o)) else $error("size"); // R7

    AST_RO_WRITE_REJECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && (idx >= (ADDR_W-6)'(NUM_CPU)))
            |=> (err_o && $stable(mask_i))) else $error("ro write"); // R6

    AST_RSP_HAS_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> $past(req_valid_i && !req_write_i && (req_size_i == 2'd3)))
        else $error("spurious rsp"); // R9

    AST_ERR_RSP_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(err_o && rsp_valid_o)) else $error("err with rsp"); // R9

endmodule

bind irq_router irq_router_chk #(
    .NUM_CPU (NUM_CPU),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dev_irq_i   (dev_irq_i),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_size_i  (req_size_i),
    .rsp_valid_o (rsp_valid_o),
    .err_o       (err_o),
    .irq_o       (irq_o),
    .mask_i      (state_q.mask),
    .raw_i       (state_q.raw)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;

    localparam int NC = 4;
    localparam int DW = 64;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] dev_irq;
    logic          req_valid;
    logic          req_write;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_size;
    logic [DW-1:0] req_wdata;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_valid;
    logic          err;
    logic [NC-1:0] irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [DW-1:0] mirror [NC];
    logic [DW-1:0] raw_m;
    logic          got_v, got_e;
    logic [DW-1:0] got_d;

    always #10 clk = ~clk;

    irq_router #(.NUM_CPU(NC), .DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .dev_irq_i   (dev_irq),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_size_i  (req_size),
        .req_wdata_i (req_wdata),
        .rsp_rdata_o (rsp_rdata),
        .rsp_valid_o (rsp_valid),
        .err_o       (err),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input int idx, input logic [5:0] off,
                          input logic [1:0] sz, input logic [DW-1:0] wd);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {idx[AW-7:0], off};
        req_size  = sz;
        req_wdata = wd;
        @(negedge clk);
        got_v = rsp_valid;
        got_d = rsp_rdata;
        got_e = err;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic [5:0] off, input logic [DW-1:0] exp);
        access(1'b0, idx, off, 2'd3, '0);
        check({tag, " rsp_valid"}, DW'(got_v), 1);
        check({tag, " rdata"}, got_d, exp);
        check({tag, " err"}, DW'(got_e), 0);
    endtask

    task automatic wr_mask(input int c, input logic [DW-1:0] val, input logic [5:0] off);
        access(1'b1, c, off, 2'd3, val);
        mirror[c] = val;
        check("R3 mask write err", DW'(got_e), 0);
    endtask

    task automatic set_raw(input logic [DW-1:0] v);
        dev_irq = v;
        raw_m   = v;
        @(negedge clk);
    endtask

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] r;
        for (int c = 0; c < NC; c++) r[c] = |(mirror[c] & raw_m);
        return r;
    endfunction

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; dev_irq = '0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_size = 2'd3; req_wdata = '0; raw_m = '0;
        for (int c = 0; c < NC; c++) mirror[c] = '0;
        dev_irq = 64'hFFFF_0000_FFFF_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        dev_irq = '0;
        // R1: reset state
        check("R1 irq", DW'(irq), 0);
        check("R1 err", DW'(err), 0);
        check("R1 rsp_valid", DW'(rsp_valid), 0);
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            rd_chk("R1 mask", c, 6'd0, '0);
            rd_chk("R1 routed", NC + c, 6'd0, '0);
        end
        rd_chk("R1 raw", 2 * NC, 6'd0, '0);

        // R3 R4 R5 R2: sweep of raw patterns and per-CPU masks
        for (int p = 0; p < 8; p++) begin
            logic [DW-1:0] rv;
            rv = (64'h1 << (p * 9)) | (64'h3 << (p * 5 + 20));
            set_raw(rv);
            check("R5 irq after raw change", DW'(irq), DW'(exp_irq()));
            for (int c = 0; c < NC; c++) begin
                logic [DW-1:0] m;
                m = (((p + c) % 2) == 1) ? ((64'h1 << (p * 9)) | (64'hF0 << c)) : ~rv;
                wr_mask(c, m, 6'd0);
                check("R5 irq after mask write", DW'(irq), DW'(exp_irq()));
            end
            for (int c = 0; c < NC; c++) begin
                rd_chk("R4 routed", NC + c, 6'd0, mirror[c] & raw_m);
                rd_chk("R3 mask", c, 6'd0, mirror[c]);
            end
            rd_chk("R2 raw", 2 * NC, 6'd0, raw_m);
        end

        // R5: drop one CPU by mask write, others hold
        for (int c = 0; c < NC; c++) wr_mask(c, '1, 6'd0);
        set_raw(64'h8);
        check("R5 all raised", DW'(irq), 64'hF);
        wr_mask(1, '0, 6'd0);
        check("R5 cpu1 dropped", DW'(irq), 64'hD);
        wr_mask(1, 64'h8, 6'd0);
        check("R5 cpu1 raised", DW'(irq), 64'hF);
        // R5: drop by falling request
        set_raw('0);
        check("R5 raw fall", DW'(irq), 0);
        rd_chk("R4 routed zero", NC + 2, 6'd0, '0);

        // R6: writes to routed and raw rejected
        set_raw(64'h00F0);
        for (int c = 0; c < NC; c++) begin
            access(1'b1, NC + c, 6'd0, 2'd3, 64'hDEAD);
            check("R6 routed write err", DW'(got_e), 1);
            check("R6 routed write no rsp", DW'(got_v), 0);
        end
        access(1'b1, 2 * NC, 6'd0, 2'd3, 64'h1234);
        check("R6 raw write err", DW'(got_e), 1);
        for (int c = 0; c < NC; c++) begin
            rd_chk("R6 routed unchanged", NC + c, 6'd0, mirror[c] & raw_m);
            rd_chk("R6 mask unchanged", c, 6'd0, mirror[c]);
        end
        rd_chk("R6 raw unchanged", 2 * NC, 6'd0, raw_m);

        // R7: narrow sizes rejected on read and write
        for (int s = 0; s < 3; s++) begin
            access(1'b1, 2, 6'd0, 2'(s), 64'h5555);
            check("R7 narrow write err", DW'(got_e), 1);
            access(1'b0, 2, 6'd0, 2'(s), '0);
            check("R7 narrow read err", DW'(got_e), 1);
            check("R7 narrow read no rsp", DW'(got_v), 0);
            rd_chk("R7 mask unchanged", 2, 6'd0, mirror[2]);
        end

        // R8: unmapped indices
        for (int i = 2 * NC + 1; i < 16; i++) begin
            access(1'b0, i, 6'd0, 2'd3, '0);
            check("R8 unmapped err", DW'(got_e), 1);
            check("R8 unmapped no rsp", DW'(got_v), 0);
        end

        // R9: response lasts one cycle
        rd_chk("R9 read", 0, 6'd0, mirror[0]);
        @(negedge clk);
        check("R9 rsp one cycle", DW'(rsp_valid), 0);
        check("R9 err idle", DW'(err), 0);

        // R10: low address bits ignored
        wr_mask(3, 64'h00F0_0000_0000_00F0, 6'h3F);
        check("R10 irq", DW'(irq), DW'(exp_irq()));
        rd_chk("R10 mask", 3, 6'h21, 64'h00F0_0000_0000_00F0);
        rd_chk("R10 routed", NC + 3, 6'h08, mirror[3] & raw_m);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule